// File: doc/BRIEF.md
# Keyboard Wake Interrupt Port

This block is a general-purpose I/O port of up to eight pins with built-in key-press wake logic. Software programs a per-pin data latch and direction bit, and can also select any subset of pins as keyboard inputs. A selected pin is always an input with its pull-up switched on, no matter what its direction bit says. Each selected pin is brought into the clock domain through a synchronizer. The selected pins are then reduced to a single "any key down" level.

When the keyboard function is globally enabled, a high-to-low change of that merged level sets a sticky flag. The flag raises an interrupt request toward the CPU unless the CPU's interrupt mask input is set. While the request is active, the block presents the fixed vector address of its service routine. Software acknowledges the event by writing a one to an acknowledge bit, normally after it has debounced the key.

All registers sit on a simple byte-wide bus with a single-cycle write strobe and a combinational read.

Top module: `kbd_wake_port`

## Requirements
- R1: After reset, the mask register (address 0x0B) and the control register (address 0x0C) read 0x00. pin_oe, pin_pu and irq_req are all 0.
- R2: For each pin n, pin_pu[n] equals mask bit n. pin_oe[n] equals direction bit n (address 0x04) AND NOT mask bit n, so pin_oe and pin_pu are never both 1 on the same pin.
- R3: With the global enable set (control bit 7 = 1), a high-to-low change on a masked pin sets the flag (control bit 6). The flag reads as 1 after the third rising clock edge that follows the pin change.
- R4: A low-to-high change on a masked pin never sets the flag.
- R5: A falling pin whose mask bit is 0 never sets the flag. A falling masked pin while the global enable is 0 also never sets the flag.
- R6: All masked pins are merged into one active-low level. While one masked pin is held low, a second masked pin going low produces no new flag event.
- R7: Writing the control register with bit 5 = 1 clears the flag. Writing it with bit 5 = 0 leaves the flag unchanged.
- R8: If a flag-setting edge and a clearing write land on the same clock edge, the flag ends up set.
- R9: irq_req is 1 exactly while the flag is 1 and cpu_imask is 0.
- R10: irq_vec equals 0x1FF4 while irq_req is 1, and 0x0000 otherwise.
- R11: Control bit 5 always reads as 0. The mask register reads back the value last written.
- R12: pin_out drives the data register (address 0x00). A read of 0x00 returns, per pin, the data register bit for driven pins and the synchronized pin level for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |
| cpu_imask | input | 1 | CPU interrupt mask, 1 blocks the request |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Service vector address while requesting |

## Verification
The hardest case to reach from the ports is a key edge that arrives on exactly the same clock edge as the software acknowledge write. The pin edge first passes through the synchronizer and the edge register, so its effect is delayed by several cycles. The stimulus therefore drops a masked pin and then waits two cycles before issuing the acknowledge write, which lines the write up with the first cycle in which the internal fall pulse is active. The merged-level case is reached in a similar way: one key is held down, the flag is cleared, and a second key is then pressed.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
   localparam int unsigned DW       = 8;
   localparam int unsigned KBIE_BIT = 7;
   localparam int unsigned FLAG_BIT = 6;
   localparam int unsigned ACK_BIT  = 5;
endpackage

// File: rtl/kbw_edge_det.sv
module kbw_edge_det #(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] mask,
   input  logic             kbie,
   output logic [NPINS-1:0] pin_sync,
   output logic             fall
);
   logic [NPINS-1:0] stage_q [SYNC_STAGES];
   logic             level;
   logic             prev_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= pin_in;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[s] <= '1;
               else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign pin_sync = stage_q[SYNC_STAGES-1];
   // merged level: low when any selected pin is low
   assign level    = ~|(mask & ~pin_sync);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level;

   assign fall = kbie & prev_q & ~level;
endmodule

// File: rtl/kbw_regs.sv
module kbw_regs
   import kbw_pkg::*;
#(
   parameter int unsigned NPINS     = 8,
   parameter int unsigned AW        = 8,
   parameter int unsigned ADDR_DATA = 'h00,
   parameter int unsigned ADDR_DIR  = 'h04,
   parameter int unsigned ADDR_MASK = 'h0B,
   parameter int unsigned ADDR_CTRL = 'h0C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   input  logic             fall,
   input  logic [NPINS-1:0] pin_sync,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] mask_q,
   output logic             kbie_q,
   output logic             flag_q,
   output logic [DW-1:0]    rdata
);
   logic wr_data, wr_dir, wr_mask, wr_ctrl, ack;
   logic [NPINS-1:0] port_view;

   assign wr_data = wr && (addr == AW'(ADDR_DATA));
   assign wr_dir  = wr && (addr == AW'(ADDR_DIR));
   assign wr_mask = wr && (addr == AW'(ADDR_MASK));
   assign wr_ctrl = wr && (addr == AW'(ADDR_CTRL));
   assign ack     = wr_ctrl && wdata[ACK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         kbie_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (wr_data) data_q <= wdata[NPINS-1:0];
         if (wr_dir)  dir_q  <= wdata[NPINS-1:0];
         if (wr_mask) mask_q <= wdata[NPINS-1:0];
         if (wr_ctrl) kbie_q <= wdata[KBIE_BIT];
         // a fresh edge outranks the acknowledge
         if (fall)     flag_q <= 1'b1;
         else if (ack) flag_q <= 1'b0;
      end
   end

   assign port_view = ((dir_q & ~mask_q) & data_q) | (~(dir_q & ~mask_q) & pin_sync);

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADDR_DATA))      rdata[NPINS-1:0] = port_view;
      else if (addr == AW'(ADDR_DIR))  rdata[NPINS-1:0] = dir_q;
      else if (addr == AW'(ADDR_MASK)) rdata[NPINS-1:0] = mask_q;
      else if (addr == AW'(ADDR_CTRL)) begin
         rdata[KBIE_BIT] = kbie_q;
         rdata[FLAG_BIT] = flag_q;
      end
   end
endmodule

// File: rtl/kbw_pad_ctl.sv
module kbw_pad_ctl #(
   parameter int unsigned NPINS = 8
) (
   input  logic [NPINS-1:0] data,
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] out,
   output logic [NPINS-1:0] oe,
   output logic [NPINS-1:0] pu
);
   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         assign out[i] = data[i];
         assign oe[i]  = dir[i] & ~mask[i];
         assign pu[i]  = mask[i];
      end
   endgenerate
endmodule

// File: rtl/kbd_wake_port.sv
module kbd_wake_port
   import kbw_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned AW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_DATA   = 'h00,
   parameter int unsigned ADDR_DIR    = 'h04,
   parameter int unsigned ADDR_MASK   = 'h0B,
   parameter int unsigned ADDR_CTRL   = 'h0C,
   parameter logic [15:0] VEC_ADDR    = 16'h1FF4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_pu,
   input  logic             cpu_imask,
   output logic             irq_req,
   output logic [15:0]      irq_vec
);
   if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
      $error("NPINS must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AW < 4) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end

   logic [NPINS-1:0] data_q, dir_q, mask_q, pin_sync;
   logic             kbie_q, flag_q, kb_fall;

   kbw_edge_det #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mask(mask_q),
      .kbie(kbie_q), .pin_sync(pin_sync), .fall(kb_fall));

   kbw_regs #(.NPINS(NPINS), .AW(AW), .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR),
              .ADDR_MASK(ADDR_MASK), .ADDR_CTRL(ADDR_CTRL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .fall(kb_fall), .pin_sync(pin_sync), .data_q(data_q), .dir_q(dir_q),
      .mask_q(mask_q), .kbie_q(kbie_q), .flag_q(flag_q), .rdata(bus_rdata));

   kbw_pad_ctl #(.NPINS(NPINS)) u_pad (
      .data(data_q), .dir(dir_q), .mask(mask_q),
      .out(pin_out), .oe(pin_oe), .pu(pin_pu));

   assign irq_req = flag_q & ~cpu_imask;
   assign irq_vec = irq_req ? VEC_ADDR : 16'h0000;
endmodule

// File: rtl/kbw_checker.sv
module kbw_checker
   import kbw_pkg::*;
#(
   parameter int unsigned NPINS     = 8,
   parameter int unsigned AW        = 8,
   parameter int unsigned ADDR_MASK = 'h0B,
   parameter int unsigned ADDR_CTRL = 'h0C,
   parameter logic [15:0] VEC_ADDR  = 16'h1FF4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_wdata,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pin_pu,
   input logic             cpu_imask,
   input logic             irq_req,
   input logic [15:0]      irq_vec,
   input logic             flag,
   input logic             fall
);
   logic ack_wr, mask_wr;
   assign ack_wr  = bus_wr && (bus_addr == AW'(ADDR_CTRL)) && bus_wdata[ACK_BIT];
   assign mask_wr = bus_wr && (bus_addr == AW'(ADDR_MASK));

   AST_PU_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> pin_pu == $past(bus_wdata[NPINS-1:0]));                       // R2
   AST_OE_PU_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_pu) == '0);                                                 // R2
   AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> flag);                                                           // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !fall) |=> !flag);                                             // R7
   AST_FLAG_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !fall) |=> !flag);                                              // R4
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_imask |-> !irq_req);                                                  // R9
   AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_vec == VEC_ADDR);                                         // R10
endmodule

bind kbd_wake_port kbw_checker #(
   .NPINS(NPINS), .AW(AW), .ADDR_MASK(ADDR_MASK), .ADDR_CTRL(ADDR_CTRL), .VEC_ADDR(VEC_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .pin_oe(pin_oe), .pin_pu(pin_pu), .cpu_imask(cpu_imask), .irq_req(irq_req),
   .irq_vec(irq_vec), .flag(flag_q), .fall(kb_fall));

// File: tb/kbd_wake_port_test.sv
`timescale 1ns/1ps
module kbd_wake_port_test;
   localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_MASK = 8'h0B, A_CTRL = 8'h0C;
   localparam int SEL_RD = 0, SEL_OE = 1, SEL_PU = 2, SEL_IRQ = 3, SEL_VEC = 4, SEL_OUT = 5;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, cpu_imask = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = 8'hFF;
   logic [7:0] bus_rdata, pin_out, pin_oe, pin_pu;
   logic irq_req;
   logic [15:0] irq_vec;

   typedef struct { string tag; int sel; logic [15:0] exp; } item_t;
   item_t sb[$];
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   kbd_wake_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_pu(pin_pu), .cpu_imask(cpu_imask), .irq_req(irq_req), .irq_vec(irq_vec));

   // monitor: compares queued expectations at the falling edge
   initial forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it = sb.pop_front();
         case (it.sel)
            SEL_RD:  act = {8'h00, bus_rdata};
            SEL_OE:  act = {8'h00, pin_oe};
            SEL_PU:  act = {8'h00, pin_pu};
            SEL_IRQ: act = {15'h0, irq_req};
            SEL_VEC: act = irq_vec;
            default: act = {8'h00, pin_out};
         endcase
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic exp_rd(input string tag, input logic [7:0] a, input logic [7:0] e);
      bus_addr = a;
      sb.push_back('{tag, SEL_RD, {8'h00, e}});
      tick();
   endtask

   task automatic exp_sig(input string tag, input int sel, input logic [15:0] e);
      sb.push_back('{tag, sel, e});
      tick();
   endtask

   task automatic settle();
      repeat (4) tick();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      exp_rd("R1 mask reset", A_MASK, 8'h00);
      exp_rd("R1 ctrl reset", A_CTRL, 8'h00);
      exp_sig("R1 oe reset", SEL_OE, 16'h0);
      exp_sig("R1 pu reset", SEL_PU, 16'h0);
      exp_sig("R1 irq reset", SEL_IRQ, 16'h0);

      wr(A_DIR, 8'hF0);
      wr(A_DATA, 8'hA5);
      exp_sig("R12 pin_out", SEL_OUT, 16'h00A5);
      exp_sig("R2 oe from dir", SEL_OE, 16'h00F0);
      wr(A_MASK, 8'h30);
      exp_sig("R2 oe forced off", SEL_OE, 16'h00C0);
      exp_sig("R2 pu from mask", SEL_PU, 16'h0030);
      exp_rd("R11 mask readback", A_MASK, 8'h30);
      exp_rd("R12 port read", A_DATA, 8'hBF);

      // global enable off: masked pin falls
      pin_in = 8'hEF; settle();
      exp_rd("R5 kbie off", A_CTRL, 8'h00);
      pin_in = 8'hFF; settle();

      wr(A_CTRL, 8'hA0);
      exp_rd("R11 ack reads zero", A_CTRL, 8'h80);

      // unmasked pin falls
      pin_in = 8'hFE; settle();
      exp_rd("R5 unmasked pin", A_CTRL, 8'h80);
      pin_in = 8'hFF; settle();

      // masked pin 4 falls: flag after third edge
      pin_in = 8'hEF; tick(); tick();
      exp_rd("R3 flag set", A_CTRL, 8'hC0);
      exp_sig("R9 irq active", SEL_IRQ, 16'h1);
      exp_sig("R10 vector", SEL_VEC, 16'h1FF4);
      cpu_imask = 1'b1;
      exp_sig("R9 irq masked", SEL_IRQ, 16'h0);
      exp_sig("R10 vector idle", SEL_VEC, 16'h0);
      cpu_imask = 1'b0;

      wr(A_CTRL, 8'h80);
      exp_rd("R7 write zero keeps flag", A_CTRL, 8'hC0);
      wr(A_CTRL, 8'hA0);
      exp_rd("R7 ack clears", A_CTRL, 8'h80);

      pin_in = 8'hFF; settle();
      exp_rd("R4 rising ignored", A_CTRL, 8'h80);

      // merged level: hold pin 4, clear, then press pin 5
      pin_in = 8'hEF; settle();
      wr(A_CTRL, 8'hA0);
      exp_rd("R6 pre-clear", A_CTRL, 8'h80);
      pin_in = 8'hCF; settle();
      exp_rd("R6 second key merged", A_CTRL, 8'h80);
      pin_in = 8'hFF; settle();

      // set and clear in the same cycle
      pin_in = 8'hDF; tick(); tick();
      wr(A_CTRL, 8'hA0);
      exp_rd("R8 set wins", A_CTRL, 8'hC0);
      wr(A_CTRL, 8'hA0);
      exp_sig("R9 irq after clear", SEL_IRQ, 16'h0);
      pin_in = 8'hFF; settle();

      tick();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule